// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Preload

This block multiplies two 16-bit operands and folds the product into a 35-bit result register. The register can take the product alone, add the product to what it holds, or subtract the product from what it holds. The X operand has its own input. The Y operand arrives on the same sixteen lines that also carry the low sixteen result bits out of the block. A small control word is captured whenever either operand is captured. That word selects accumulate, subtract, signed or unsigned operands, and rounding.

The result register is seen as three parts: low (bits 15:0), high (bits 31:16) and extension (bits 34:32). Each part has its own bidirectional lines and its own active-low output enable. When preload is asserted together with the result strobe, the register takes its new value straight from those lines. This lets software seed an accumulation or restore a saved sum. Alongside every tristate part, the block also brings out the part's register value and a drive flag.

All strobes are clock enables on one clock, and the synchronous reset clears every register.

Top module: `mac16_unit`

## Requirements
- R1: A synchronous reset clears the X, Y, control and result registers, so the three part values read zero after reset.
- R2: X is captured from `x_in` on a cycle with `x_ld` high. Y is captured from the low lines `io_lo` on a cycle with `y_ld` high. Each operand register holds its value on other cycles.
- R3: The control word {accumulate, subtract, two's complement, round} is captured on any cycle with `x_ld` or `y_ld` high. Control inputs on other cycles have no effect on results.
- R4: With the captured accumulate bit at 0, a result strobe loads the extended product alone, and the subtract bit has no effect.
- R5: With accumulate 1 and subtract 0, the result becomes the previous result plus the product, modulo 2^35.
- R6: With accumulate 1 and subtract 1, the result becomes the previous result minus the product, modulo 2^35 (0 minus 1 gives all ones).
- R7: With the two's-complement bit at 1, both operands are signed and the product is sign-extended to 35 bits. With it at 0, both operands are unsigned and the product is zero-extended.
- R8: With the round bit at 1, the value 2^15 (a one at bit 15) is added to the new result.
- R9: When `p_ld` and `preload` are both high, the result register loads {`io_ext`, `io_hi`, `io_lo`} as bits 34:32, 31:16 and 15:0. With `preload` low, the values on `io_hi` and `io_ext` are ignored.
- R10: With `p_ld` low, the result register holds its value.
- R11: When a part's active-low enable is 0, that part's register value drives its lines and its drive flag is 1. When the enable is 1, the lines are released and the flag is 0.
- R12: A result strobe uses the operand and control registers as they stood before that clock edge. An operand captured on the same edge affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 16 | X operand data |
| x_ld | input | 1 | Capture X and the control word |
| y_ld | input | 1 | Capture Y from `io_lo` and the control word |
| p_ld | input | 1 | Update the result register |
| acc_en | input | 1 | Accumulate select |
| sub_en | input | 1 | Subtract select (used when accumulating) |
| tc_en | input | 1 | Signed operand select |
| rnd_en | input | 1 | Round select |
| preload | input | 1 | Result strobe loads from the part lines |
| oe_lo_n | input | 1 | Low part output enable, active low |
| oe_hi_n | input | 1 | High part output enable, active low |
| oe_ext_n | input | 1 | Extension part output enable, active low |
| io_lo | inout | 16 | Y operand in / low part out / low preload in |
| io_hi | inout | 16 | High part out / high preload in |
| io_ext | inout | 3 | Extension part out / extension preload in |
| lo_val | output | 16 | Low part register value |
| hi_val | output | 16 | High part register value |
| ext_val | output | 3 | Extension part register value |
| lo_drv | output | 1 | Low part is driving its lines |
| hi_drv | output | 1 | High part is driving its lines |
| ext_drv | output | 1 | Extension part is driving its lines |

## Verification
Operands and the control word are captured at one edge. A result strobe on any later cycle shows its value on the part outputs right after the edge where `p_ld` was sampled high, so a new result is one register stage behind its strobe. The bench's driver task computes the expected register value for that edge and queues it. The monitor compares it at the following falling edge, which means every cycle, including hold cycles, is checked exactly one half period after its edge. Drive flags and driven lines follow the enables without a register, so those checks sample a short delay after the enables change, away from the clock edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic acc;
    logic sub;
    logic tc;
    logic rnd;
  } mac_ctrl_t;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'd0,
    MODE_ADD  = 2'd1,
    MODE_SUB  = 2'd2
  } mac_mode_t;

  function automatic mac_mode_t mode_of(input mac_ctrl_t c);
    if (!c.acc)     return MODE_LOAD;
    else if (c.sub) return MODE_SUB;
    else            return MODE_ADD;
  endfunction

endpackage

// File: rtl/mac_operand_regs.sv
module mac_operand_regs
  import mac_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           x_ld,
  input  logic           y_ld,
  input  logic [OPW-1:0] x_in,
  input  logic [OPW-1:0] y_in,
  input  mac_ctrl_t      ctrl_in,
  output logic [OPW-1:0] x_q,
  output logic [OPW-1:0] y_q,
  output mac_ctrl_t      ctrl_q,
  output logic           ctrl_we
);

  // Control word travels with whichever operand is being captured.
  assign ctrl_we = x_ld | y_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      ctrl_q <= '0;
    end else begin
      if (x_ld)    x_q    <= x_in;
      if (y_ld)    y_q    <= y_in;
      if (ctrl_we) ctrl_q <= ctrl_in;
    end
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OPW  = 16,
  parameter int EXTW = 3,
  localparam int AW  = 2 * OPW + EXTW
) (
  input  logic [OPW-1:0] x_q,
  input  logic [OPW-1:0] y_q,
  input  logic           tc,
  output logic [AW-1:0]  prod_ext
);

  // Widen both operands to the accumulator width first; the truncated
  // product is then the exact product modulo 2^AW in either mode.
  function automatic logic [AW-1:0] widen_mul(input logic [OPW-1:0] a,
                                              input logic [OPW-1:0] b,
                                              input logic           signed_ops);
    logic [AW-1:0] wa;
    logic [AW-1:0] wb;
    if (signed_ops) begin
      wa = {{(AW-OPW){a[OPW-1]}}, a};
      wb = {{(AW-OPW){b[OPW-1]}}, b};
    end else begin
      wa = {{(AW-OPW){1'b0}}, a};
      wb = {{(AW-OPW){1'b0}}, b};
    end
    return wa * wb;
  endfunction

  assign prod_ext = widen_mul(x_q, y_q, tc);

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int EXTW = 3,
  localparam int AW  = 2 * OPW + EXTW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_ld,
  input  logic          preload,
  input  mac_ctrl_t     ctrl_q,
  input  logic [AW-1:0] prod_ext,
  input  logic [AW-1:0] pre_bus,
  output logic [AW-1:0] acc_q,
  output logic          preload_we,
  output logic          arith_we
);

  localparam logic [AW-1:0] RND_ONE = {{(AW-1){1'b0}}, 1'b1} << (OPW - 1);

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] prev,
                                         input logic [AW-1:0] prod,
                                         input mac_ctrl_t     c);
    logic [AW-1:0] base;
    case (mode_of(c))
      MODE_ADD: base = prev + prod;
      MODE_SUB: base = prev - prod;
      default:  base = prod;
    endcase
    return c.rnd ? base + RND_ONE : base;
  endfunction

  assign preload_we = p_ld & preload;
  assign arith_we   = p_ld & ~preload;

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (preload_we) acc_q <= pre_bus;
    else if (arith_we)   acc_q <= fold(acc_q, prod_ext, ctrl_q);
  end

endmodule

// File: rtl/mac_part_port.sv
module mac_part_port #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         oe_n,
  output logic         drv,
  inout  wire  [W-1:0] pad
);

  assign drv = ~oe_n;
  assign pad = drv ? val : {W{1'bz}};

endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int EXTW = 3,
  localparam int AW  = 2 * OPW + EXTW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  x_in,
  input  logic            x_ld,
  input  logic            y_ld,
  input  logic            p_ld,
  input  logic            acc_en,
  input  logic            sub_en,
  input  logic            tc_en,
  input  logic            rnd_en,
  input  logic            preload,
  input  logic            oe_lo_n,
  input  logic            oe_hi_n,
  input  logic            oe_ext_n,
  inout  wire  [OPW-1:0]  io_lo,
  inout  wire  [OPW-1:0]  io_hi,
  inout  wire  [EXTW-1:0] io_ext,
  output logic [OPW-1:0]  lo_val,
  output logic [OPW-1:0]  hi_val,
  output logic [EXTW-1:0] ext_val,
  output logic            lo_drv,
  output logic            hi_drv,
  output logic            ext_drv
);

  mac_ctrl_t      ctrl_in;
  mac_ctrl_t      ctrl_q;
  logic           ctrl_we;
  logic [OPW-1:0] x_q;
  logic [OPW-1:0] y_q;
  logic [AW-1:0]  prod_ext;
  logic [AW-1:0]  pre_bus;
  logic [AW-1:0]  acc_q;
  logic           preload_we;
  logic           arith_we;

  assign ctrl_in = '{acc: acc_en, sub: sub_en, tc: tc_en, rnd: rnd_en};
  assign pre_bus = {io_ext, io_hi, io_lo};

  mac_operand_regs #(.OPW(OPW)) u_ops (
    .clk     (clk),
    .rst     (rst),
    .x_ld    (x_ld),
    .y_ld    (y_ld),
    .x_in    (x_in),
    .y_in    (io_lo),
    .ctrl_in (ctrl_in),
    .x_q     (x_q),
    .y_q     (y_q),
    .ctrl_q  (ctrl_q),
    .ctrl_we (ctrl_we)
  );

  mac_mult #(.OPW(OPW), .EXTW(EXTW)) u_mult (
    .x_q      (x_q),
    .y_q      (y_q),
    .tc       (ctrl_q.tc),
    .prod_ext (prod_ext)
  );

  mac_accum #(.OPW(OPW), .EXTW(EXTW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .p_ld       (p_ld),
    .preload    (preload),
    .ctrl_q     (ctrl_q),
    .prod_ext   (prod_ext),
    .pre_bus    (pre_bus),
    .acc_q      (acc_q),
    .preload_we (preload_we),
    .arith_we   (arith_we)
  );

  assign lo_val  = acc_q[OPW-1:0];
  assign hi_val  = acc_q[2*OPW-1:OPW];
  assign ext_val = acc_q[AW-1:2*OPW];

  mac_part_port #(.W(OPW)) u_port_lo (
    .val (lo_val), .oe_n (oe_lo_n), .drv (lo_drv), .pad (io_lo)
  );

  mac_part_port #(.W(OPW)) u_port_hi (
    .val (hi_val), .oe_n (oe_hi_n), .drv (hi_drv), .pad (io_hi)
  );

  mac_part_port #(.W(EXTW)) u_port_ext (
    .val (ext_val), .oe_n (oe_ext_n), .drv (ext_drv), .pad (io_ext)
  );

endmodule

// File: rtl/mac16_checks.sv
module mac16_checks #(
  parameter int OPW  = 16,
  parameter int EXTW = 3,
  localparam int AW  = 2 * OPW + EXTW
) (
  input logic           clk,
  input logic           rst,
  input logic           x_ld,
  input logic           x_ld_or_y_ld,
  input logic           p_ld,
  input logic           preload,
  input logic           oe_lo_n,
  input logic           oe_hi_n,
  input logic           oe_ext_n,
  input logic           lo_drv,
  input logic           hi_drv,
  input logic           ext_drv,
  input logic [OPW-1:0] x_in,
  input logic [OPW-1:0] x_q,
  input logic [3:0]     ctrl_q,
  input logic [AW-1:0]  prod_ext,
  input logic [AW-1:0]  pre_bus,
  input logic [AW-1:0]  acc_q
);

  // R1: a reset cycle leaves a cleared result register behind it
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> acc_q == '0);

  // R2: X follows its strobe and holds otherwise
  p_x_capture_r2: assert property (@(posedge clk) disable iff (rst)
    x_ld |=> x_q == $past(x_in));
  p_x_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !x_ld |=> $stable(x_q));

  // R3: control word only moves with an operand strobe
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !x_ld_or_y_ld |=> $stable(ctrl_q));

  // R4: plain load with no accumulate and no round takes the product
  p_plain_load_r4: assert property (@(posedge clk) disable iff (rst)
    (p_ld && !preload && !ctrl_q[3] && !ctrl_q[0]) |=> acc_q == $past(prod_ext));

  // R9: preload takes the three part buses
  p_preload_r9: assert property (@(posedge clk) disable iff (rst)
    (p_ld && preload) |=> acc_q == $past(pre_bus));

  // R10: no strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !p_ld |=> $stable(acc_q));

  // R11: each drive flag tracks its own enable
  p_drive_lo_r11: assert property (@(posedge clk) disable iff (rst)
    lo_drv != oe_lo_n);
  p_drive_hi_r11: assert property (@(posedge clk) disable iff (rst)
    hi_drv != oe_hi_n);
  p_drive_ext_r11: assert property (@(posedge clk) disable iff (rst)
    ext_drv != oe_ext_n);

endmodule

bind mac16_unit mac16_checks #(.OPW(OPW), .EXTW(EXTW)) u_checks (
  .clk          (clk),
  .rst          (rst),
  .x_ld         (x_ld),
  .x_ld_or_y_ld (ctrl_we),
  .p_ld         (p_ld),
  .preload      (preload),
  .oe_lo_n      (oe_lo_n),
  .oe_hi_n      (oe_hi_n),
  .oe_ext_n     (oe_ext_n),
  .lo_drv       (lo_drv),
  .hi_drv       (hi_drv),
  .ext_drv      (ext_drv),
  .x_in         (x_in),
  .x_q          (x_q),
  .ctrl_q       (ctrl_q),
  .prod_ext     (prod_ext),
  .pre_bus      (pre_bus),
  .acc_q        (acc_q)
);

// File: tb/tb_mac16_unit.sv
`timescale 1ns/1ps
module tb_mac16_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0;
  logic        x_ld = 0, y_ld = 0, p_ld = 0;
  logic        acc_en = 0, sub_en = 0, tc_en = 0, rnd_en = 0, preload = 0;
  logic        oe_lo_n = 1, oe_hi_n = 1, oe_ext_n = 1;
  logic [15:0] lo_val, hi_val;
  logic [2:0]  ext_val;
  logic        lo_drv, hi_drv, ext_drv;

  logic        tb_lo_en = 0, tb_hi_en = 0, tb_ext_en = 0;
  logic [15:0] tb_lo = '0, tb_hi = '0;
  logic [2:0]  tb_ext = '0;
  wire  [15:0] io_lo;
  wire  [15:0] io_hi;
  wire  [2:0]  io_ext;
  assign io_lo  = tb_lo_en  ? tb_lo  : 16'hzzzz;
  assign io_hi  = tb_hi_en  ? tb_hi  : 16'hzzzz;
  assign io_ext = tb_ext_en ? tb_ext : 3'bzzz;

  always #4 clk = ~clk;  // 125 MHz

  mac16_unit dut (
    .clk(clk), .rst(rst), .x_in(x_in), .x_ld(x_ld), .y_ld(y_ld), .p_ld(p_ld),
    .acc_en(acc_en), .sub_en(sub_en), .tc_en(tc_en), .rnd_en(rnd_en),
    .preload(preload), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n), .oe_ext_n(oe_ext_n),
    .io_lo(io_lo), .io_hi(io_hi), .io_ext(io_ext),
    .lo_val(lo_val), .hi_val(hi_val), .ext_val(ext_val),
    .lo_drv(lo_drv), .hi_drv(hi_drv), .ext_drv(ext_drv)
  );

  int nchk = 0;
  int nerr = 0;

  // reference state
  logic [15:0] mx = '0, my = '0;
  logic [3:0]  mctrl = '0;  // {acc, sub, tc, rnd}
  logic [34:0] macc = '0;

  // scoreboard
  logic [34:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [34:0] ref_next(input logic [15:0] a, input logic [15:0] b,
                                           input logic [3:0] c, input logic [34:0] prev);
    longint p;
    logic [34:0] pp, res;
    if (c[1]) p = longint'($signed(a)) * longint'($signed(b));
    else      p = longint'(a) * longint'(b);
    pp = p[34:0];
    if (!c[3])    res = pp;
    else if (c[2]) res = prev - pp;
    else           res = prev + pp;
    if (c[0]) res = res + 35'h0_0000_8000;
    return res;
  endfunction

  // driver: one cycle of stimulus, expected result queued for the monitor
  task automatic op(input string tag,
                    input bit xl, input logic [15:0] xv,
                    input bit yl, input logic [15:0] yv,
                    input bit pl, input bit pre, input logic [34:0] pv,
                    input bit a, input bit s, input bit t, input bit r);
    logic [34:0] nacc;
    @(negedge clk);
    x_ld = xl; x_in = xv; y_ld = yl; p_ld = pl; preload = pre;
    acc_en = a; sub_en = s; tc_en = t; rnd_en = r;
    oe_lo_n = 1; oe_hi_n = 1; oe_ext_n = 1;
    tb_lo_en  = yl | pre; tb_lo  = pre ? pv[15:0] : yv;
    tb_hi_en  = 1'b1;     tb_hi  = pre ? pv[31:16] : 16'hA5C3;
    tb_ext_en = 1'b1;     tb_ext = pre ? pv[34:32] : 3'b110;
    nacc = macc;
    if (pl) nacc = pre ? pv : ref_next(mx, my, mctrl, macc);
    @(posedge clk);
    macc = nacc;
    if (xl) mx = xv;
    if (yl) my = yv;
    if (xl | yl) mctrl = {a, s, t, r};
    exp_q.push_back(macc);
    tag_q.push_back(tag);
  endtask

  // monitor: compare one half period after each result edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [34:0] e;
        string       tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, {29'b0, ext_val, hi_val, lo_val}, {29'b0, e});
      end
    end
  end

  // R11: enables vs drive flags and driven lines
  task automatic oe_check(input bit lo_n, input bit hi_n, input bit ext_n);
    @(negedge clk);
    x_ld = 0; y_ld = 0; p_ld = 0; preload = 0;
    tb_lo_en = 0; tb_hi_en = 0; tb_ext_en = 0;
    oe_lo_n = lo_n; oe_hi_n = hi_n; oe_ext_n = ext_n;
    #1;
    chk("R11 lo_drv",  {63'b0, lo_drv},  {63'b0, !lo_n});
    chk("R11 hi_drv",  {63'b0, hi_drv},  {63'b0, !hi_n});
    chk("R11 ext_drv", {63'b0, ext_drv}, {63'b0, !ext_n});
    if (!lo_n)  chk("R11 io_lo",  {48'b0, io_lo},  {48'b0, macc[15:0]});
    if (!hi_n)  chk("R11 io_hi",  {48'b0, io_hi},  {48'b0, macc[31:16]});
    if (!ext_n) chk("R11 io_ext", {61'b0, io_ext}, {61'b0, macc[34:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset value", {29'b0, ext_val, hi_val, lo_val}, 64'h0);
    chk("R1 reset drive", {61'b0, lo_drv, hi_drv, ext_drv}, 64'h0);
    rst = 0;

    // R7 unsigned: FFFF*FFFF
    op("R2 load", 1, 16'hFFFF, 1, 16'hFFFF, 0, 0, '0, 0, 0, 0, 0);
    op("R7 unsigned", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R7 signed: -1*-1
    op("R2 load", 1, 16'hFFFF, 1, 16'hFFFF, 0, 0, '0, 0, 0, 1, 0);
    op("R7 signed", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R7 signed negative product
    op("R2 load", 1, 16'h8000, 1, 16'h7FFF, 0, 0, '0, 0, 0, 1, 0);
    op("R7 signed neg", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R4 subtract ignored without accumulate
    op("R2 load", 1, 16'd3, 1, 16'd5, 0, 0, '0, 0, 1, 0, 0);
    op("R4 load only", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R5 add
    op("R2 load", 1, 16'd100, 1, 16'd200, 0, 0, '0, 1, 0, 0, 0);
    op("R5 add", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    op("R5 add again", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R6 subtract
    op("R2 load", 1, 16'd7, 1, 16'd7, 0, 0, '0, 1, 1, 0, 0);
    op("R6 sub", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R6 wrap below zero
    op("R9 preload zero", 0, 0, 0, 0, 1, 1, 35'h0, 0, 0, 0, 0);
    op("R2 load", 1, 16'd1, 1, 16'd1, 0, 0, '0, 1, 1, 0, 0);
    op("R6 wrap", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R8 round
    op("R2 load", 1, 16'd2, 1, 16'd3, 0, 0, '0, 0, 0, 0, 1);
    op("R8 round", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R9 preload distinct parts
    op("R9 preload", 0, 0, 0, 0, 1, 1, {3'h5, 16'hDEAD, 16'hBEEF}, 0, 0, 0, 0);
    // R10 hold with no strobe, bus junk present
    op("R10 hold", 0, 0, 0, 0, 0, 0, '0, 1, 1, 1, 1);
    op("R10 hold", 0, 0, 0, 0, 0, 1, 35'h1_2345_6789, 0, 0, 0, 0);
    // R3 control inputs at strobe time ignored
    op("R2 load", 1, 16'd9, 1, 16'd11, 0, 0, '0, 1, 0, 0, 0);
    op("R3 latched ctrl", 0, 0, 0, 0, 1, 0, '0, 0, 1, 1, 1);
    // R9 hi/ext lines ignored without preload (junk driven by op)
    op("R9 ignored lines", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R12 same-edge operand capture uses old operands
    op("R12 same edge", 1, 16'd4, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    op("R12 new operand", 0, 0, 0, 0, 1, 0, '0, 0, 0, 0, 0);
    // R11 enables
    oe_check(0, 1, 1);
    oe_check(1, 0, 1);
    oe_check(1, 1, 0);
    oe_check(0, 0, 0);
    oe_check(1, 1, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule